// File: doc/BRIEF.md
# Gated Power-of-Two Clock Prescaler

This block takes a free-running master clock and produces a clock divided by a power of two. A 4-bit exponent selects the ratio, from 1 (the master clock passed straight through) to 256. After reset the output stays low until the master clock has run for a fixed startup count. Once that count is done, a ready flag goes high and the output may toggle.

Two controls gate the output. An output-enable input lets the divided clock through or holds it low. A power-down request, once it has stayed high long enough to pass a duration filter, freezes the divider, clears the ready flag and holds the output low. Releasing power-down restarts the startup count. Enabling, disabling and ratio changes take effect only on a divided-clock boundary, so the output never shows a shortened pulse.

The reset input is asynchronous and active low. A two-stage synchronizer releases it on a master clock edge. A boundary is a master rising edge at which the divider's low x bits are all ones, so that the divided level goes (or stays) low at that edge. With x = 0, every master rising edge is a boundary.

Top module: `clkpre_top`

## Requirements
- R1: While rst_ni is low, and from its release until ready_o rises, clk_o and ready_o are both 0.
- R2: ready_o rises on the 514th master rising edge after rst_ni is released. That is 2 edges of reset synchronization plus a startup count of 512 cycles.
- R3: With div_exp_i = x in 0..8 and the output enabled, clk_o has a period of 2^x master cycles and a 50% duty cycle. For x >= 1 it is a registered level. For x = 0 it is high exactly while the master clock is high.
- R4: div_exp_i values 9 to 15 divide by 256, the same as 8.
- R5: While out_en_i is low, clk_o stays low. out_en_i is sampled only at boundaries, so gating starts and stops on those edges.
- R6: Every high phase of clk_o is complete: 2^(x-1) master cycles for x >= 1, or a full master high phase for x = 0. Disabling waits for the current high phase to end. Enabling waits for the next rising boundary.
- R7: A new div_exp_i value is applied at the next boundary of the old ratio. At that edge the divider restarts from zero, so the new ratio begins with a full low phase.
- R8: A power-down request that stays high for fewer than 2*2^x consecutive sampled master edges is ignored. ready_o stays high and the output keeps running.
- R9: A power-down request that has been high for at least 2*2^x consecutive sampled edges is accepted at a boundary. At that edge ready_o clears, clk_o goes low and the divider freezes.
- R10: After power-down is released, ready_o rises on the 512th master rising edge after the first edge that samples pwr_dn_i low.
- R11: ready_o falls only on reset or on an accepted power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk_i | input | 1 | Free-running master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_exp_i | input | 4 | Divide exponent x, ratio 2^x |
| out_en_i | input | 1 | Output enable, applied at boundaries |
| pwr_dn_i | input | 1 | Power-down request, duration filtered |
| clk_o | output | 1 | Divided, gated clock |
| ready_o | output | 1 | Startup count done and not powered down |

## Verification
A fixed sweep over every exponent from 0 to 8, plus one out-of-range value, measures the high-phase count and the number of rising transitions in a 512-cycle window. This separates an off-by-one tap, a missing clamp and a broken pass-through. Directed cases apply a power-down pulse just short of the filter limit and one well past it, then count edges through both startup counts. These separate a filter that is too short from one that is too long, and a restart count that is off by one. A seeded random phase mixes exponent changes in mid-period, out-enable toggles and power-down pulses of random length. It compares every half-cycle against a reference model, which exposes any truncated or extra pulse at a gating or ratio change.

// File: rtl/clkpre_pkg.sv
`timescale 1ns/100ps
package clkpre_pkg;

  // Power sequencing state of the prescaler
  typedef enum logic [1:0] {
    PS_START = 2'd0,
    PS_RUN   = 2'd1,
    PS_DOWN  = 2'd2
  } pwr_state_e;

endpackage

// File: rtl/clkpre_rst_sync.sv
`timescale 1ns/100ps
module clkpre_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sh_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q[g] <= 1'b0;
        else         sh_q[g] <= 1'b1;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q[g] <= 1'b0;
        else         sh_q[g] <= sh_q[g-1];
      end
    end
  end

  assign rst_no = sh_q[STAGES-1];

endmodule

// File: rtl/clkpre_divider.sv
`timescale 1ns/100ps
module clkpre_divider #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned EXP_W = 4,
  localparam int unsigned ACT_W = $clog2(CNT_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EXP_W-1:0] exp_i,
  input  logic             hold_i,   // next state is powered down
  output logic             bnd_o,    // this edge is a boundary
  output logic [ACT_W-1:0] act_q_o,
  output logic [ACT_W-1:0] act_d_o,
  output logic [CNT_W-1:0] cnt_d_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [ACT_W-1:0] act_q, act_d;
  logic [ACT_W-1:0] exp_c;
  logic [CNT_W:0]   mask_w;
  logic [CNT_W-1:0] mask;

  // clamp the requested exponent to the counter width
  always_comb begin
    if (int'(exp_i) > int'(CNT_W)) exp_c = ACT_W'(CNT_W);
    else                           exp_c = ACT_W'(exp_i);
  end

  // low act bits all ones: divided level drops (or stays low) here
  assign mask_w = ({{CNT_W{1'b0}}, 1'b1} << act_q) - 1'b1;
  assign mask   = mask_w[CNT_W-1:0];
  assign bnd_o  = &(cnt_q | ~mask);

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q + 1'b1;
    if (hold_i) begin
      cnt_d = '0;
    end else if (bnd_o && (exp_c != act_q)) begin
      act_d = exp_c;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign act_q_o = act_q;
  assign act_d_o = act_d;
  assign cnt_d_o = cnt_d;

endmodule

// File: rtl/clkpre_ctrl.sv
`timescale 1ns/100ps
module clkpre_ctrl
  import clkpre_pkg::*;
#(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned START_CYC  = 512,
  parameter int unsigned PD_PERIODS = 2,
  localparam int unsigned ACT_W = $clog2(CNT_W + 1),
  localparam int unsigned ST_W  = $clog2(START_CYC),
  localparam int unsigned PD_W  = $clog2(PD_PERIODS << CNT_W) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bnd_i,
  input  logic [ACT_W-1:0] act_q_i,
  input  logic             pd_i,
  input  logic             oe_i,
  output logic             hold_o,
  output logic             gate_d_o,
  output logic             gate_q_o,
  output logic             down_o,
  output logic             ready_o
);

  pwr_state_e      state_q, state_d;
  logic [ST_W-1:0] st_q, st_d;
  logic [PD_W-1:0] pd_q, pd_d;
  logic [PD_W-1:0] limit;
  logic            gate_q, gate_d;
  logic            accept;

  assign limit = PD_W'(PD_PERIODS) << act_q_i;

  // consecutive-high filter on the power-down request
  always_comb begin
    pd_d = '0;
    if (pd_i && (state_q != PS_DOWN)) begin
      pd_d = (pd_q == '1) ? pd_q : pd_q + 1'b1;
    end
  end

  assign accept = pd_i && bnd_i && (state_q != PS_DOWN) && (pd_d >= limit);

  always_comb begin
    state_d = state_q;
    st_d    = st_q;
    unique case (state_q)
      PS_START: begin
        if (accept) begin
          state_d = PS_DOWN;
        end else if (st_q == ST_W'(START_CYC - 1)) begin
          state_d = PS_RUN;
        end else begin
          st_d = st_q + 1'b1;
        end
      end
      PS_RUN: begin
        if (accept) state_d = PS_DOWN;
      end
      PS_DOWN: begin
        if (!pd_i) begin
          state_d = PS_START;
          st_d    = '0;
        end
      end
      default: state_d = PS_START;
    endcase
  end

  // gate only moves on a boundary edge
  assign gate_d = bnd_i ? ((state_d == PS_RUN) && oe_i) : gate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PS_START;
      st_q    <= '0;
      pd_q    <= '0;
      gate_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      st_q    <= st_d;
      pd_q    <= pd_d;
      gate_q  <= gate_d;
    end
  end

  assign hold_o   = (state_d == PS_DOWN);
  assign gate_d_o = gate_d;
  assign gate_q_o = gate_q;
  assign down_o   = (state_q == PS_DOWN);
  assign ready_o  = (state_q == PS_RUN);

endmodule

// File: rtl/clkpre_outgate.sv
`timescale 1ns/100ps
module clkpre_outgate #(
  parameter int unsigned CNT_W = 8,
  localparam int unsigned ACT_W = $clog2(CNT_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gate_d_i,
  input  logic             gate_q_i,
  input  logic [ACT_W-1:0] act_d_i,
  input  logic [ACT_W-1:0] act_q_i,
  input  logic [CNT_W-1:0] cnt_d_i,
  output logic             clk_o
);

  logic [CNT_W:0]   oh_w;
  logic [CNT_W-1:0] tap;
  logic             lvl_d, lvl_q;
  logic             sel_q, g0_q;

  // one-hot tap on bit act-1; empty when act is zero
  assign oh_w  = {{CNT_W{1'b0}}, 1'b1} << act_d_i;
  assign tap   = oh_w[CNT_W:1];
  assign lvl_d = gate_d_i && (|(cnt_d_i & tap));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_d;
  end

  // pass-through select and enable change while the master clock is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= 1'b0;
      g0_q  <= 1'b0;
    end else begin
      sel_q <= (act_q_i == '0);
      g0_q  <= gate_q_i && (act_q_i == '0);
    end
  end

  assign clk_o = sel_q ? (clk_i & g0_q) : lvl_q;

endmodule

// File: rtl/clkpre_top.sv
`timescale 1ns/100ps
module clkpre_top #(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned EXP_W       = 4,
  parameter int unsigned START_CYC   = 512,
  parameter int unsigned PD_PERIODS  = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             mclk_i,
  input  logic             rst_ni,
  input  logic [EXP_W-1:0] div_exp_i,
  input  logic             out_en_i,
  input  logic             pwr_dn_i,
  output logic             clk_o,
  output logic             ready_o
);

  localparam int unsigned ACT_W = $clog2(CNT_W + 1);

  logic             rst_n_sync;
  logic             bnd, hold, gate_d, gate_q, down;
  logic [ACT_W-1:0] act_q, act_d;
  logic [CNT_W-1:0] cnt_d;

  clkpre_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i (mclk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n_sync)
  );

  clkpre_divider #(.CNT_W(CNT_W), .EXP_W(EXP_W)) u_div (
    .clk_i  (mclk_i),
    .rst_ni (rst_n_sync),
    .exp_i  (div_exp_i),
    .hold_i (hold),
    .bnd_o  (bnd),
    .act_q_o(act_q),
    .act_d_o(act_d),
    .cnt_d_o(cnt_d)
  );

  clkpre_ctrl #(
    .CNT_W(CNT_W), .START_CYC(START_CYC), .PD_PERIODS(PD_PERIODS)
  ) u_ctrl (
    .clk_i   (mclk_i),
    .rst_ni  (rst_n_sync),
    .bnd_i   (bnd),
    .act_q_i (act_q),
    .pd_i    (pwr_dn_i),
    .oe_i    (out_en_i),
    .hold_o  (hold),
    .gate_d_o(gate_d),
    .gate_q_o(gate_q),
    .down_o  (down),
    .ready_o (ready_o)
  );

  clkpre_outgate #(.CNT_W(CNT_W)) u_out (
    .clk_i   (mclk_i),
    .rst_ni  (rst_n_sync),
    .gate_d_i(gate_d),
    .gate_q_i(gate_q),
    .act_d_i (act_d),
    .act_q_i (act_q),
    .cnt_d_i (cnt_d),
    .clk_o   (clk_o)
  );

endmodule

// File: rtl/clkpre_chk.sv
`timescale 1ns/100ps
module clkpre_chk #(
  parameter int unsigned CNT_W = 8,
  localparam int unsigned ACT_W = $clog2(CNT_W + 1)
) (
  input logic             mclk_i,
  input logic             rst_n,
  input logic             pwr_dn_i,
  input logic             ready_o,
  input logic             gate_q,
  input logic             bnd,
  input logic             down,
  input logic [ACT_W-1:0] act_q
);

  // R5 / R6: gating moves only after a boundary edge
  a_r6_gate_on_boundary: assert property (@(posedge mclk_i) disable iff (!rst_n)
    !$stable(gate_q) |-> $past(bnd));

  // R7: ratio switches only after a boundary edge
  a_r7_exp_on_boundary: assert property (@(posedge mclk_i) disable iff (!rst_n)
    !$stable(act_q) |-> $past(bnd));

  // R4: active exponent never exceeds the counter width
  a_r4_exp_in_range: assert property (@(posedge mclk_i) disable iff (!rst_n)
    act_q <= ACT_W'(CNT_W));

  // R8: power-down is entered only on a standing request
  a_r8_down_needs_request: assert property (@(posedge mclk_i) disable iff (!rst_n)
    $rose(down) |-> $past(pwr_dn_i));

  // R9 / R11: ready falls only into power-down, with the gate closed
  a_r9_ready_drop_closes: assert property (@(posedge mclk_i) disable iff (!rst_n)
    $fell(ready_o) |-> (down && !gate_q));

  // R10: leaving power-down does not release ready at once
  a_r10_exit_not_ready: assert property (@(posedge mclk_i) disable iff (!rst_n)
    $fell(down) |-> !ready_o);

endmodule

bind clkpre_top clkpre_chk #(.CNT_W(CNT_W)) u_chk (
  .mclk_i  (mclk_i),
  .rst_n   (rst_n_sync),
  .pwr_dn_i(pwr_dn_i),
  .ready_o (ready_o),
  .gate_q  (gate_q),
  .bnd     (bnd),
  .down    (down),
  .act_q   (act_q)
);

// File: tb/clkpre_top_tb_top.sv
`timescale 1ns/100ps
module clkpre_top_tb_top;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic [3:0] div_exp;
  logic       oe, pd;
  logic       clk_o, ready_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit sample_on = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;   // 250 MHz

  clkpre_top dut_i (
    .mclk_i   (clk),
    .rst_ni   (rst_ni),
    .div_exp_i(div_exp),
    .out_en_i (oe),
    .pwr_dn_i (pd),
    .clk_o    (clk_o),
    .ready_o  (ready_o)
  );

  // ---------------- reference model, written from the requirements -------
  logic [1:0] m_rs;
  int  m_state, m_st, m_pd, m_cnt, m_act;
  bit  m_gate, m_lvl, m_sel, m_g0;

  function automatic int clampx(int x);
    return (x > 8) ? 8 : x;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_rs <= 2'b00; m_state <= 0; m_st <= 0; m_pd <= 0;
      m_cnt <= 0; m_act <= 0; m_gate <= 0; m_lvl <= 0;
    end else begin
      m_rs <= {m_rs[0], 1'b1};
      if (m_rs[1]) begin : step
        bit b, acc, ng;
        int np, ns, nst, nc, na;
        b   = ((m_cnt + 1) % (1 << m_act)) == 0;
        np  = (pd && m_state != 2) ? ((m_pd + 1 > 1023) ? 1023 : m_pd + 1) : 0;
        acc = pd && b && (m_state != 2) && (np >= (2 << m_act));
        ns = m_state; nst = m_st;
        if (m_state == 0) begin
          if (acc) ns = 2;
          else if (m_st == 511) ns = 1;
          else nst = m_st + 1;
        end else if (m_state == 1) begin
          if (acc) ns = 2;
        end else if (!pd) begin
          ns = 0; nst = 0;
        end
        na = m_act;
        if (ns == 2) nc = 0;
        else if (b && clampx(int'(div_exp)) != m_act) begin
          na = clampx(int'(div_exp)); nc = 0;
        end else nc = (m_cnt + 1) % 256;
        ng = b ? ((ns == 1) && oe) : m_gate;
        m_pd <= np; m_state <= ns; m_st <= nst; m_cnt <= nc; m_act <= na;
        m_gate <= ng;
        m_lvl <= ng && (na != 0) && (((nc >> (na - 1)) & 1) == 1);
      end
    end
  end

  always @(negedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_sel <= 0; m_g0 <= 0;
    end else if (m_rs[1]) begin
      m_sel <= (m_act == 0);
      m_g0  <= m_gate && (m_act == 0);
    end
  end

  // ---------------- checking helpers ----------------
  task automatic check(string req, int act, int exp_v, string what);
    checks++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp_v, $time);
    end
  endtask

  // half-cycle comparison against the model
  initial begin
    wait (sample_on);
    forever begin
      @(posedge clk); #1;
      check(cur_req, clk_o, m_sel ? int'(m_g0) : int'(m_lvl), "clk_o high phase");
      check(cur_req, ready_o, int'(m_state == 1), "ready_o");
      @(negedge clk); #1;
      check(cur_req, clk_o, m_sel ? 0 : int'(m_lvl), "clk_o low phase");
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1.5;
  endtask

  // count high samples, rises and low-phase highs over n cycles
  task automatic measure(int n, output int hs, output int rises, output int lows);
    bit prev, v;
    hs = 0; rises = 0; lows = 0;
    @(posedge clk); #1; prev = clk_o;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1; lows += int'(clk_o);
      @(posedge clk); #1; v = clk_o;
      hs += int'(v);
      if (v && !prev) rises++;
      prev = v;
    end
    #0.5;
  endtask

  // ---------------- stimulus ----------------
  initial begin
    int hs, rs, lw;
    rst_ni = 1'b0; div_exp = 4'd0; oe = 1'b1; pd = 1'b0;
    #9;
    sample_on = 1;
    tick(3);
    check("R1", clk_o, 0, "clk_o in reset");
    check("R1", ready_o, 0, "ready_o in reset");
    rst_ni = 1'b1;

    // R2: exact ready timing
    cur_req = "R2";
    repeat (513) @(posedge clk);
    #1; check("R2", ready_o, 0, "ready before edge 514");
    check("R1", clk_o, 0, "clk_o before ready");
    @(posedge clk); #1;
    check("R2", ready_o, 1, "ready after edge 514");
    #0.5;

    // R3: ratio sweep
    cur_req = "R3";
    for (int x = 0; x <= 8; x++) begin
      div_exp = 4'(x);
      tick(300);
      measure(512, hs, rs, lw);
      if (x == 0) begin
        check("R3", hs, 512, "x=0 high-phase count");
        check("R3", lw, 0, "x=0 low-phase count");
      end else begin
        check("R3", hs, 256, $sformatf("x=%0d high count", x));
        check("R3", rs, 512 >> x, $sformatf("x=%0d rises", x));
        check("R3", lw, 256, $sformatf("x=%0d low-phase count", x));
      end
    end

    // R4: out-of-range exponent clamps to 8
    cur_req = "R4";
    div_exp = 4'd13;
    tick(300);
    measure(512, hs, rs, lw);
    check("R4", rs, 2, "x=13 rises");
    check("R4", hs, 256, "x=13 high count");

    // R5: output enable low holds clock low
    cur_req = "R5";
    div_exp = 4'd3;
    tick(40);
    oe = 1'b0;
    tick(20);
    measure(200, hs, rs, lw);
    check("R5", hs + lw, 0, "clk_o while disabled");
    oe = 1'b1;
    tick(20);
    measure(64, hs, rs, lw);
    check("R5", rs, 8, "rises after re-enable");

    // R7: mid-period ratio changes
    cur_req = "R7";
    div_exp = 4'd5; tick(37);
    div_exp = 4'd1; tick(13);
    div_exp = 4'd0; tick(9);
    div_exp = 4'd4; tick(50);
    check("R7", ready_o, 1, "ready through ratio changes");

    // R8: short power-down pulse at x=2 (limit 8 edges)
    cur_req = "R8";
    div_exp = 4'd2; tick(20);
    pd = 1'b1; tick(5); pd = 1'b0;
    tick(20);
    check("R8", ready_o, 1, "ready after short pulse");
    measure(32, hs, rs, lw);
    check("R11", rs, 8, "clock still running after short pulse");

    // R9: accepted power-down
    cur_req = "R9";
    pd = 1'b1; tick(40);
    check("R9", ready_o, 0, "ready during power-down");
    measure(30, hs, rs, lw);
    check("R9", hs + lw, 0, "clk_o during power-down");

    // R10: restart count after release
    cur_req = "R10";
    pd = 1'b0;
    repeat (512) @(posedge clk);
    #1; check("R10", ready_o, 0, "ready before restart count ends");
    @(posedge clk); #1;
    check("R10", ready_o, 1, "ready after restart count");
    #0.5;

    // R6: seeded random mix against the model
    cur_req = "R6";
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 1500; i++) begin
      int sel;
      sel = int'($urandom_range(0, 15));
      if (sel == 0) begin
        pd = 1'b1; tick(int'($urandom_range(1, 300))); pd = 1'b0;
      end else if (sel < 6) begin
        div_exp = 4'($urandom_range(0, 10));
      end else if (sel < 9) begin
        oe = ~oe;
      end
      tick(int'($urandom_range(1, 40)));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #760000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish by %0t", $time);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule